// File: doc/BRIEF.md
# USB DMA Descriptor Completion Controller

This block governs how a per-endpoint DMA transfer between a USB endpoint buffer and system memory comes to an end when it is driven by a chain of descriptors. A descriptor is handed over with a byte length, a link-valid flag for the next descriptor and a direction. The block counts the bytes moved by each bus beat. When the length is used up, it decides whether to go on to the linked descriptor or to stop. It then writes a completion status and raises an end-of-transfer pulse.

A buffer can run out in the middle of a packet. If a link exists, the block asks for the next descriptor, and the rest of the packet carries on under it. If no link exists, the outcome depends on direction. An OUT endpoint ends in overrun and loses its DMA enable. An IN endpoint ends normally and the packet leaves as a short packet. A zero-length descriptor completes at once; on an IN endpoint it also emits a zero-length packet.

Memory bus mastering, descriptor fetch from RAM and the USB serial engine are outside the block. Each of them is reduced to a one-cycle handshake.

Top module: `udd_desc_close`

## Requirements
- R1: After reset, every `dma_en` bit is 0, `desc_status` is 0 (not serviced), and `beat_ready`, `fetch_req`, `eot_pulse`, `short_pkt` and `zlp_pulse` are all 0.
- R2: A `1` in bit i of `en_set` sets `dma_en[i]` at the next edge. A start is accepted only while the block is idle and `dma_en[start_ep]` is 1; a start that is not accepted leaves `beat_ready` at 0 and `desc_status` unchanged.
- R3: An accepted start or fetched descriptor with a non-zero length makes `beat_ready` 1 and `desc_status` 1 (being serviced) from the next cycle.
- R4: Each accepted beat lowers the remaining count by `beat_bytes` (1 to 4). A beat that brings the count to zero or below ends the descriptor: `eot_pulse` is high for the single cycle after that edge, carrying `eot_ep` and `eot_status`, and `desc_status` takes the same code.
- R5: When a descriptor ends on a beat flagged `beat_pkt_end`, the status is 2 (normal completion). If its link is valid, `fetch_req` rises in the same cycle as `eot_pulse`; otherwise the block returns to idle.
- R6: When a descriptor ends mid-packet with a valid link, the status is 2 and `fetch_req` rises. A `fetch_ack` loads the fetched length and link flag, and beats continue on the same endpoint.
- R7: When an OUT descriptor (`start_is_in`=0) ends mid-packet with no valid link, the status is 3 (overrun) and `dma_en` for that endpoint is 0 in the same cycle as `eot_pulse`. Later starts on that endpoint are ignored until `en_set` sets the bit again; when both happen at one edge, the clear wins.
- R8: When an IN descriptor (`start_is_in`=1) ends mid-packet with no valid link, the status is 2, `short_pkt` pulses together with `eot_pulse`, and the block goes idle.
- R9: A descriptor loaded with length 0, whether by start or by fetch, completes one cycle after the load edge with status 2 and the block goes idle. On an IN endpoint `zlp_pulse` pulses with `eot_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | NUM_EP | One-cycle mask that sets DMA enable bits |
| dma_en | output | NUM_EP | Per-endpoint DMA enable |
| start_valid | input | 1 | Offer of a first descriptor |
| start_ep | input | EP_W | Endpoint of the offered descriptor |
| start_is_in | input | 1 | 1 for IN (to USB), 0 for OUT (to memory) |
| start_len | input | LEN_W | Buffer length in bytes |
| start_link_ok | input | 1 | Linked descriptor is valid |
| beat_ready | output | 1 | Block is counting beats |
| beat_valid | input | 1 | A bus beat moved data this cycle |
| beat_bytes | input | BB_W | Valid bytes in the beat, 1 to BUS_BYTES |
| beat_pkt_end | input | 1 | Beat is the last of a USB packet |
| fetch_req | output | 1 | Linked descriptor requested |
| fetch_ack | input | 1 | Linked descriptor fields present |
| fetch_len | input | LEN_W | Buffer length of the fetched descriptor |
| fetch_link_ok | input | 1 | Link-valid flag of the fetched descriptor |
| eot_pulse | output | 1 | End-of-transfer interrupt, one cycle |
| eot_ep | output | EP_W | Endpoint of the finished descriptor |
| eot_status | output | 4 | Final status code (2 normal, 3 overrun) |
| short_pkt | output | 1 | IN packet leaves short, transfer ends |
| zlp_pulse | output | 1 | Zero-length IN packet is to be sent |
| desc_status | output | 4 | Status of the latest descriptor (0, 1, 2, 3) |

## Verification
Every output of this block is registered. A start, beat or fetch acknowledge taken at one rising edge therefore shows its effect in the cycle right after that edge: the end pulse with its endpoint and code, the status, the fetch request, the short or zero-length flag and the enable clear all appear together there. The bench drives inputs shortly after each falling edge. A behavioural model steps at every rising edge from the same inputs, and the bench compares all outputs with that model at the next falling edge, exactly one register stage later. Directed sequences cover chaining mid-packet, overrun and re-enable, short IN packets and zero-length descriptors. A random phase then mixes beat widths, packet ends and link flags.

// File: rtl/udd_pkg.sv
package udd_pkg;

   typedef enum logic [3:0] {
      DS_UNSERVED = 4'd0,
      DS_BUSY     = 4'd1,
      DS_NORMAL   = 4'd2,
      DS_OVERRUN  = 4'd3
   } dd_status_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_MOVE = 2'd1,
      PH_LINK = 2'd2
   } phase_e;

   typedef struct packed {
      logic       done;
      logic       chain;
      logic       short_pkt;
      logic       overrun;
      dd_status_e code;
   } end_verdict_t;

endpackage

// File: rtl/udd_byte_cnt.sv
module udd_byte_cnt #(
   parameter int LEN_W     = 16,
   parameter int BUS_BYTES = 4,
   localparam int BB_W     = $clog2(BUS_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_len,
   input  logic             dec,
   input  logic [BB_W-1:0]  dec_bytes,
   output logic [LEN_W-1:0] rem,
   output logic             hit
);

   if (BUS_BYTES < 1 || BUS_BYTES > 64) begin : g_bad_bus
      initial $fatal(1, "udd_byte_cnt: BUS_BYTES out of range");
   end
   if (LEN_W <= BB_W) begin : g_bad_len
      initial $fatal(1, "udd_byte_cnt: LEN_W too small for beat width");
   end

   logic [LEN_W-1:0] step;
   assign step = LEN_W'(dec_bytes);
   assign hit  = dec && (step >= rem);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem <= '0;
      else if (load)
         rem <= load_len;
      else if (dec)
         rem <= hit ? '0 : rem - step;
   end

endmodule

// File: rtl/udd_end_decide.sv
module udd_end_decide
   import udd_pkg::*;
(
   input  logic         hit,
   input  logic         pkt_end,
   input  logic         link_ok,
   input  logic         is_in,
   output end_verdict_t verdict
);

   always_comb begin
      verdict = '{done: 1'b0, chain: 1'b0, short_pkt: 1'b0,
                  overrun: 1'b0, code: DS_NORMAL};
      if (hit) begin
         verdict.done = 1'b1;
         if (pkt_end || link_ok) begin
            verdict.chain = link_ok;
         end else if (is_in) begin
            verdict.short_pkt = 1'b1;
         end else begin
            verdict.overrun = 1'b1;
            verdict.code    = DS_OVERRUN;
         end
      end
   end

endmodule

// File: rtl/udd_ep_enable.sv
module udd_ep_enable #(
   parameter int NUM_EP = 16,
   localparam int EP_W  = $clog2(NUM_EP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] set_mask,
   input  logic              clr_valid,
   input  logic [EP_W-1:0]   clr_ep,
   output logic [NUM_EP-1:0] en
);

   if (NUM_EP < 2 || NUM_EP > 32) begin : g_bad_ep
      initial $fatal(1, "udd_ep_enable: NUM_EP out of range");
   end

   for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
      logic kill;
      assign kill = clr_valid && (clr_ep == EP_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en[i] <= 1'b0;
         else if (kill)
            en[i] <= 1'b0;
         else if (set_mask[i])
            en[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/udd_desc_close.sv
module udd_desc_close
   import udd_pkg::*;
#(
   parameter int NUM_EP    = 16,
   parameter int LEN_W     = 16,
   parameter int BUS_BYTES = 4,
   localparam int EP_W     = $clog2(NUM_EP),
   localparam int BB_W     = $clog2(BUS_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] en_set,
   output logic [NUM_EP-1:0] dma_en,
   input  logic              start_valid,
   input  logic [EP_W-1:0]   start_ep,
   input  logic              start_is_in,
   input  logic [LEN_W-1:0]  start_len,
   input  logic              start_link_ok,
   output logic              beat_ready,
   input  logic              beat_valid,
   input  logic [BB_W-1:0]   beat_bytes,
   input  logic              beat_pkt_end,
   output logic              fetch_req,
   input  logic              fetch_ack,
   input  logic [LEN_W-1:0]  fetch_len,
   input  logic              fetch_link_ok,
   output logic              eot_pulse,
   output logic [EP_W-1:0]   eot_ep,
   output logic [3:0]        eot_status,
   output logic              short_pkt,
   output logic              zlp_pulse,
   output logic [3:0]        desc_status
);

   phase_e       phase;
   logic [EP_W-1:0] cur_ep;
   logic         cur_in;
   logic         cur_link;
   dd_status_e   dstat_q;
   dd_status_e   eot_code_q;

   logic         start_ok, fetch_ok, load, load_zero, load_in, load_link;
   logic [LEN_W-1:0] load_len;
   logic [EP_W-1:0]  load_ep;
   logic         beat_take, hit;
   logic [LEN_W-1:0] rem;
   end_verdict_t verdict;

   assign start_ok  = (phase == PH_IDLE) && start_valid && dma_en[start_ep];
   assign fetch_ok  = (phase == PH_LINK) && fetch_ack;
   assign load      = start_ok || fetch_ok;
   assign load_len  = start_ok ? start_len     : fetch_len;
   assign load_link = start_ok ? start_link_ok : fetch_link_ok;
   assign load_in   = start_ok ? start_is_in   : cur_in;
   assign load_ep   = start_ok ? start_ep      : cur_ep;
   assign load_zero = load && (load_len == '0);
   assign beat_take = (phase == PH_MOVE) && beat_valid;

   udd_byte_cnt #(.LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_len  (load_len),
      .dec       (beat_take),
      .dec_bytes (beat_bytes),
      .rem       (rem),
      .hit       (hit)
   );

   udd_end_decide i_decide (
      .hit     (hit),
      .pkt_end (beat_pkt_end),
      .link_ok (cur_link),
      .is_in   (cur_in),
      .verdict (verdict)
   );

   udd_ep_enable #(.NUM_EP(NUM_EP)) i_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mask  (en_set),
      .clr_valid (beat_take && verdict.overrun),
      .clr_ep    (cur_ep),
      .en        (dma_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cur_ep     <= '0;
         cur_in     <= 1'b0;
         cur_link   <= 1'b0;
         dstat_q    <= DS_UNSERVED;
         eot_code_q <= DS_UNSERVED;
         eot_ep     <= '0;
         eot_pulse  <= 1'b0;
         short_pkt  <= 1'b0;
         zlp_pulse  <= 1'b0;
      end else begin
         eot_pulse <= 1'b0;
         short_pkt <= 1'b0;
         zlp_pulse <= 1'b0;
         if (start_ok) begin
            cur_ep <= start_ep;
            cur_in <= start_is_in;
         end
         if (load) begin
            cur_link <= load_link;
            if (load_zero) begin
               eot_pulse  <= 1'b1;
               eot_ep     <= load_ep;
               eot_code_q <= DS_NORMAL;
               dstat_q    <= DS_NORMAL;
               zlp_pulse  <= load_in;
               phase      <= PH_IDLE;
            end else begin
               dstat_q <= DS_BUSY;
               phase   <= PH_MOVE;
            end
         end else if (beat_take && verdict.done) begin
            eot_pulse  <= 1'b1;
            eot_ep     <= cur_ep;
            eot_code_q <= verdict.code;
            dstat_q    <= verdict.code;
            short_pkt  <= verdict.short_pkt;
            phase      <= verdict.chain ? PH_LINK : PH_IDLE;
         end
      end
   end

   assign beat_ready  = (phase == PH_MOVE);
   assign fetch_req   = (phase == PH_LINK);
   assign eot_status  = eot_code_q;
   assign desc_status = dstat_q;

   // R3: beats are counted only while the descriptor reads as being serviced
   a_r3_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      beat_ready |-> (desc_status == 4'd1));

   // R5: fetching and counting never overlap
   a_r5_fetch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && beat_ready));

   // R4: status output agrees with the end pulse code
   a_r4_eot_status: assert property (@(posedge clk) disable iff (!rst_n)
      eot_pulse |-> (desc_status == eot_status));

   // R7: an overrun leaves the endpoint disabled in the same cycle
   a_r7_overrun_off: assert property (@(posedge clk) disable iff (!rst_n)
      (eot_pulse && eot_status == 4'd3) |-> !dma_en[eot_ep]);

   // R8: a short packet is always a normal completion pulse
   a_r8_short_eot: assert property (@(posedge clk) disable iff (!rst_n)
      short_pkt |-> (eot_pulse && eot_status == 4'd2 && !fetch_req));

   // R9: zero-length packet only with a normal end and idle afterwards
   a_r9_zlp_eot: assert property (@(posedge clk) disable iff (!rst_n)
      zlp_pulse |-> (eot_pulse && eot_status == 4'd2 && !beat_ready));

endmodule

// File: tb/test_udd_desc_close.sv
module test_udd_desc_close;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_EP = 16;
   localparam int LEN_W  = 16;
   localparam int EP_W   = 4;
   localparam int BB_W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_EP-1:0] en_set;
   logic [NUM_EP-1:0] dma_en;
   logic start_valid, start_is_in, start_link_ok;
   logic [EP_W-1:0] start_ep;
   logic [LEN_W-1:0] start_len, fetch_len;
   logic beat_ready, beat_valid, beat_pkt_end;
   logic [BB_W-1:0] beat_bytes;
   logic fetch_req, fetch_ack, fetch_link_ok;
   logic eot_pulse, short_pkt, zlp_pulse;
   logic [EP_W-1:0] eot_ep;
   logic [3:0] eot_status, desc_status;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   udd_desc_close i_udd_desc_close (
      .clk(clk), .rst_n(rst_n), .en_set(en_set), .dma_en(dma_en),
      .start_valid(start_valid), .start_ep(start_ep), .start_is_in(start_is_in),
      .start_len(start_len), .start_link_ok(start_link_ok),
      .beat_ready(beat_ready), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
      .beat_pkt_end(beat_pkt_end), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
      .fetch_len(fetch_len), .fetch_link_ok(fetch_link_ok),
      .eot_pulse(eot_pulse), .eot_ep(eot_ep), .eot_status(eot_status),
      .short_pkt(short_pkt), .zlp_pulse(zlp_pulse), .desc_status(desc_status)
   );

   // behavioural reference: phase 0 idle, 1 counting, 2 waiting for link
   int m_ph, m_ep, m_in, m_rem, m_link, m_en;
   int m_eot, m_eep, m_est, m_short, m_zlp, m_dst;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_ep = 0; m_in = 0; m_rem = 0; m_link = 0; m_en = 0;
         m_eot = 0; m_eep = 0; m_est = 0; m_short = 0; m_zlp = 0; m_dst = 0;
      end else begin
         int en_nxt, ld, lenv, lkv;
         en_nxt = m_en | int'(en_set);
         ld = 0; lenv = 0; lkv = 0;
         m_eot = 0; m_short = 0; m_zlp = 0;
         if (m_ph == 0 && start_valid && ((m_en >> start_ep) & 1) == 1) begin
            m_ep = int'(start_ep); m_in = int'(start_is_in);
            ld = 1; lenv = int'(start_len); lkv = int'(start_link_ok);
         end else if (m_ph == 2 && fetch_ack) begin
            ld = 1; lenv = int'(fetch_len); lkv = int'(fetch_link_ok);
         end else if (m_ph == 1 && beat_valid) begin
            if (int'(beat_bytes) >= m_rem) begin
               m_rem = 0; m_eot = 1; m_eep = m_ep;
               if (beat_pkt_end || m_link == 1) begin
                  m_est = 2; m_ph = (m_link == 1) ? 2 : 0;
               end else if (m_in == 1) begin
                  m_est = 2; m_short = 1; m_ph = 0;
               end else begin
                  m_est = 3; m_ph = 0; en_nxt = en_nxt & ~(1 << m_ep);
               end
               m_dst = m_est;
            end else begin
               m_rem = m_rem - int'(beat_bytes);
            end
         end
         if (ld == 1) begin
            m_link = lkv; m_rem = lenv;
            if (lenv == 0) begin
               m_eot = 1; m_eep = m_ep; m_est = 2; m_zlp = m_in;
               m_dst = 2; m_ph = 0;
            end else begin
               m_dst = 1; m_ph = 1;
            end
         end
         m_en = en_nxt;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         cycles++;
         if (!rst_n) begin
            // R1 reset state
         end else if (cycles > 4 && cycles < 6) begin
            chk("R1", "dma_en", int'(dma_en), 0);
            chk("R1", "desc_status", int'(desc_status), 0);
            chk("R1", "beat_ready", int'(beat_ready), 0);
            chk("R1", "fetch_req", int'(fetch_req), 0);
            chk("R1", "pulses", int'({eot_pulse, short_pkt, zlp_pulse}), 0);
         end else begin
            chk("R2/R7", "dma_en", int'(dma_en), m_en);
            chk("R3", "beat_ready", int'(beat_ready), m_ph == 1 ? 1 : 0);
            chk("R3", "desc_status", int'(desc_status), m_dst);
            chk("R4", "eot_pulse", int'(eot_pulse), m_eot);
            if (m_eot == 1) begin
               chk("R4", "eot_ep", int'(eot_ep), m_eep);
               chk("R4", "eot_status", int'(eot_status), m_est);
            end
            chk("R5/R6", "fetch_req", int'(fetch_req), m_ph == 2 ? 1 : 0);
            chk("R8", "short_pkt", int'(short_pkt), m_short);
            chk("R9", "zlp_pulse", int'(zlp_pulse), m_zlp);
         end
      end
   end

   task automatic next_cyc();
      @(negedge clk);
      #1;
      en_set = '0; start_valid = 0; start_ep = '0; start_is_in = 0;
      start_len = '0; start_link_ok = 0; beat_valid = 0; beat_bytes = '0;
      beat_pkt_end = 0; fetch_ack = 0; fetch_len = '0; fetch_link_ok = 0;
   endtask

   task automatic t_en(input int mask);
      next_cyc(); en_set = NUM_EP'(mask);
   endtask

   task automatic t_start(input int ep, input int dir_in, input int len, input int lk);
      next_cyc(); start_valid = 1; start_ep = EP_W'(ep); start_is_in = dir_in[0];
      start_len = LEN_W'(len); start_link_ok = lk[0];
   endtask

   task automatic t_beat(input int b, input int e);
      next_cyc(); beat_valid = 1; beat_bytes = BB_W'(b); beat_pkt_end = e[0];
   endtask

   task automatic t_fetch(input int len, input int lk);
      next_cyc(); fetch_ack = 1; fetch_len = LEN_W'(len); fetch_link_ok = lk[0];
   endtask

   task automatic t_idle(input int n);
      for (int i = 0; i < n; i++) next_cyc();
   endtask

   initial begin
      en_set = '0; start_valid = 0; start_ep = '0; start_is_in = 0;
      start_len = '0; start_link_ok = 0; beat_valid = 0; beat_bytes = '0;
      beat_pkt_end = 0; fetch_ack = 0; fetch_len = '0; fetch_link_ok = 0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      t_idle(4);
      // R2: start without enable is ignored
      t_start(3, 0, 8, 0); t_idle(2);
      chk("R2", "ignored start beat_ready", int'(beat_ready), 0);
      // R4/R5: OUT length 10, ends exactly on packet end
      t_en(16'h0028);
      t_start(3, 0, 10, 0);
      t_beat(4, 0); t_beat(4, 0); t_beat(2, 1); t_idle(2);
      // R6 then R7: chain mid-packet, then overrun
      t_start(3, 0, 6, 1);
      t_beat(4, 0); t_beat(2, 0); t_idle(1);
      t_fetch(5, 0);
      t_beat(3, 1); t_beat(2, 0); t_idle(2);
      chk("R7", "dma_en[3] after overrun", int'(dma_en[3]), 0);
      t_start(3, 0, 4, 0); t_idle(2);
      chk("R7", "start after overrun ignored", int'(beat_ready), 0);
      t_en(16'h0008); t_start(3, 0, 2, 0); t_beat(2, 1); t_idle(2);
      // R8: IN, no link, runs out mid-packet
      t_start(5, 1, 3, 0);
      t_beat(1, 0); t_beat(1, 0); t_beat(1, 0); t_idle(2);
      // R9: IN chain to zero-length descriptor
      t_start(5, 1, 4, 1);
      t_beat(4, 1); t_idle(1); t_fetch(0, 1); t_idle(2);
      // R9: OUT zero-length start, and beat while idle ignored
      t_start(3, 0, 0, 0); t_beat(4, 1); t_idle(2);
      // R4: oversize beat clamps to zero
      t_start(5, 0, 2, 0); t_beat(4, 1); t_idle(2);
      // R7: set and clear at the same edge, clear wins
      t_start(3, 0, 1, 0);
      next_cyc(); beat_valid = 1; beat_bytes = 3'd1; en_set = 16'h0008;
      t_idle(2);
      // random phase
      for (int k = 0; k < 4000; k++) begin
         next_cyc();
         if (($urandom % 16) == 0) en_set = NUM_EP'($urandom);
         if (m_ph == 0) begin
            if (($urandom % 3) == 0) begin
               start_valid = 1; start_ep = EP_W'($urandom);
               start_is_in = 1'($urandom); start_len = LEN_W'($urandom % 14);
               start_link_ok = 1'($urandom);
            end
         end else if (m_ph == 1) begin
            if (($urandom % 4) != 0) begin
               beat_valid = 1; beat_bytes = BB_W'(1 + $urandom % 4);
               beat_pkt_end = (($urandom % 3) == 0);
            end
         end else if (($urandom % 2) == 0) begin
            fetch_ack = 1; fetch_len = LEN_W'($urandom % 10);
            fetch_link_ok = 1'($urandom);
         end
      end
      t_idle(3);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule